// File: doc/BRIEF.md
# Six-Bit Port with Split Open-Drain Control

This block is a six-bit general-purpose port. Software writes an output data latch and a direction register through a small register interface. Each pin with its direction bit set is driven from the latch. Each pin can drive push-pull, or it can drive open-drain so that several devices can share a line in wired-OR fashion. Open-drain operation is chosen per pin group by two independent enable inputs. A neighbouring controller drives these enables. One enable covers the four high pins (bits 5..2). The other covers the two low pins (bits 1..0).

Each pin has three separate outputs: a low-side drive, a high-side drive and an output enable. With these, the pad ring or a testbench can resolve the pin level, and no tristate net is needed inside the block. In open-drain mode only the high-side drive is suppressed, so a latched 0 still pulls the pin low. A latched 1 leaves the pin floating, and an external pull-up then sets its level. A read of the data register returns the sampled pin levels, not the latch contents. This works the same in every operating mode of the chip.

Top module: `split_od_port`

## Requirements
- R1: After reset the data latch and the direction register are 0. Every pin_oe bit is 0, and a read at addr=1 returns 0.
- R2: A pin whose direction bit is 0 asserts neither drv_low nor drv_high nor pin_oe, whatever the state of its group enable.
- R3: A pin with direction 1 and latched 0 asserts drv_low and not drv_high, whatever the state of its group enable.
- R4: A pin with direction 1 and latched 1, whose group enable is 0, asserts drv_high and not drv_low.
- R5: While wom_hi_en is 1, drv_high is 0 on bits 5..2. A latched 1 on those pins leaves pin_oe at 0.
- R6: While wom_lo_en is 1, drv_high is 0 on bits 1..0. The lower group is independent of wom_hi_en, and the upper group is independent of wom_lo_en.
- R7: drv_low and drv_high are never both 1 on the same pin, and pin_oe equals drv_low OR drv_high on each pin.
- R8: With addr=0, rdata shows pin_in as it was at the previous rising clock edge. On an open-drain pin left floating, an external pull-low therefore reads back as 0.
- R9: A write with wr_en=1 and addr=1 loads the direction register. A read with addr=1 then returns that value.
- R10: A write with wr_en=1 and addr=0 loads the data latch even while the pins are inputs. The value appears on the drivers once the direction is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 = data, 1 = direction |
| wdata | input | 6 | Write data |
| rdata | output | 6 | Read data: sampled pins (addr 0) or direction (addr 1) |
| wom_hi_en | input | 1 | Open-drain enable for bits 5..2 |
| wom_lo_en | input | 1 | Open-drain enable for bits 1..0 |
| pin_in | input | 6 | Resolved pin levels from the pad |
| drv_low | output | 6 | Low-side driver on, per pin |
| drv_high | output | 6 | High-side driver on, per pin |
| pin_oe | output | 6 | Pin actively driven, per pin |

## Verification
The assertions check four things on every cycle. Neither driver may be active on an input pin. The two drivers never conflict. Each group enable holds its high-side drives off. The data readback follows the pins one cycle late. Only the bench scenarios can show the rest. These include the exact driver pattern for every combination of latch, direction and group enables; the register write and readback sequences; a latch value written while the pin is an input; and a floating open-drain line read as low while an external device pulls it down.

// File: rtl/split_od_port_pkg.sv
// Package: shared register-select encoding for the split open-drain port.
// Assumes a one-bit register address on the bus side.
package split_od_port_pkg;
    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_DIR  = 1'b1
    } port_sel_e;
endpackage

// File: rtl/split_od_port_regs.sv
// Module: data latch and direction register.
// Assumes one write strobe plus a select; reset is synchronous, active low.
module split_od_port_regs
    import split_od_port_pkg::*;
#(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  port_sel_e        sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);
    // Load the selected register on a write; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (wr_en) begin
            if (sel == SEL_DATA) latch_q <= wdata;
            else                 dir_q   <= wdata;
        end
    end
endmodule

// File: rtl/split_od_port_drv.sv
// Module: driver control for one pin.
// Assumes an open-drain request only removes the high-side drive.
module split_od_port_drv (
    input  logic dir,
    input  logic dat,
    input  logic od_en,
    output logic drv_lo,
    output logic drv_hi,
    output logic oe
);
    // Choose which driver (if any) is on for this pin.
    always_comb begin
        drv_lo = dir & ~dat;
        drv_hi = dir & dat & ~od_en;
        oe     = drv_lo | drv_hi;
    end
endmodule

// File: rtl/split_od_port_sample.sv
// Module: register that samples the pin levels for readback.
// Assumes pin_in is already synchronous, or its timing is handled at the pad.
module split_od_port_sample #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_q
);
    // Capture the pin levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_in;
    end
endmodule

// File: rtl/split_od_port.sv
// Module: six-bit port with group-wise open-drain selection.
// Pins below LOW_W follow wom_lo_en; the remaining pins follow wom_hi_en.
// Assumes the pad resolves the drive signals and returns levels on pin_in.
module split_od_port
    import split_od_port_pkg::*;
#(
    parameter int WIDTH = 6,
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic             wom_hi_en,
    input  logic             wom_lo_en,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] drv_low,
    output logic [WIDTH-1:0] drv_high,
    output logic [WIDTH-1:0] pin_oe
);
    port_sel_e        sel;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_q;

    assign sel = port_sel_e'(addr);

    split_od_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (wdata),
        .latch_q(latch_q),
        .dir_q  (dir_q)
    );

    split_od_port_sample #(.WIDTH(WIDTH)) u_sample (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(pin_in),
        .pin_q (pin_q)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic od_sel;
        if (i < LOW_W) begin : g_lo
            assign od_sel = wom_lo_en;
        end else begin : g_hi
            assign od_sel = wom_hi_en;
        end
        split_od_port_drv u_drv (
            .dir   (dir_q[i]),
            .dat   (latch_q[i]),
            .od_en (od_sel),
            .drv_lo(drv_low[i]),
            .drv_hi(drv_high[i]),
            .oe    (pin_oe[i])
        );
    end

    // Return sampled pins or the direction register on reads.
    always_comb begin
        rdata = (sel == SEL_DATA) ? pin_q : dir_q;
    end
endmodule

// File: rtl/split_od_port_chk.sv
// Checker: cycle-by-cycle properties of the split open-drain port.
// Assumes it is bound into split_od_port and can see dir_q there.
module split_od_port_chk #(
    parameter int WIDTH = 6,
    parameter int LOW_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr,
    input logic             wom_hi_en,
    input logic             wom_lo_en,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] rdata,
    input logic [WIDTH-1:0] drv_low,
    input logic [WIDTH-1:0] drv_high,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] dir_q
);
    localparam logic [WIDTH-1:0] LO_MASK = WIDTH'((1 << LOW_W) - 1);
    localparam logic [WIDTH-1:0] HI_MASK = ~LO_MASK;

    logic run_q;
    // Record that one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    a_r2_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | drv_low | drv_high) & ~dir_q) == '0);

    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_low & drv_high) == '0);

    a_r5_upper_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        wom_hi_en |-> ((drv_high & HI_MASK) == '0));

    a_r6_lower_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        wom_lo_en |-> ((drv_high & LO_MASK) == '0));

    a_r8_pin_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !addr) |-> (rdata == $past(pin_in)));
endmodule

bind split_od_port split_od_port_chk #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wom_hi_en(wom_hi_en),
    .wom_lo_en(wom_lo_en),
    .pin_in   (pin_in),
    .rdata    (rdata),
    .drv_low  (drv_low),
    .drv_high (drv_high),
    .pin_oe   (pin_oe),
    .dir_q    (dir_q)
);

// File: tb/split_od_port_test.sv
module split_od_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         addr = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         wom_hi_en = 1'b0;
    logic         wom_lo_en = 1'b0;
    logic [W-1:0] pin_in;
    logic [W-1:0] drv_low, drv_high, pin_oe;
    logic [W-1:0] ext_low = '0;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // Pad model: low drive wins, then high drive, else pull-up unless pulled low outside.
    assign pin_in = ~drv_low & (drv_high | ~ext_low);

    split_od_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wom_hi_en(wom_hi_en), .wom_lo_en(wom_lo_en),
        .pin_in(pin_in), .drv_low(drv_low), .drv_high(drv_high), .pin_oe(pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic a, input logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; addr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] odm, e_lo, e_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "pin_oe", pin_oe, '0);
        addr = 1'b1; #1;
        check("R1", "dir readback", rdata, '0);
        addr = 1'b0;
        // R10 / R1: latch reset to 0 seen once pins become outputs
        write_reg(1'b1, 6'h3F);
        check("R1", "drv_low latch reset", drv_low, 6'h3F);
        // R9: direction readback
        write_reg(1'b1, 6'h2A);
        addr = 1'b1; #1;
        check("R9", "dir readback", rdata, 6'h2A);
        addr = 1'b0;
        // R10: latch loads while pins are inputs
        write_reg(1'b1, 6'h00);
        write_reg(1'b0, 6'h15);
        check("R10", "no drive while input", pin_oe, '0);
        write_reg(1'b1, 6'h3F);
        check("R10", "latched value on drive", drv_high, 6'h15);
        check("R10", "latched zeros on drive", drv_low, 6'h2A);

        // Sweep every group-enable, direction and data combination.
        for (int m = 0; m < 4; m++) begin
            wom_hi_en = m[1]; wom_lo_en = m[0];
            odm = {{(W-2){m[1]}}, {2{m[0]}}};
            for (int d = 0; d < 64; d++) begin
                write_reg(1'b1, W'(d));
                for (int v = 0; v < 64; v++) begin
                    write_reg(1'b0, W'(v));
                    @(negedge clk);
                    e_lo = W'(d) & ~W'(v);
                    e_hi = W'(d) & W'(v) & ~odm;
                    check("R3", "drv_low", drv_low, e_lo);
                    check(m[1] ? "R5" : (m[0] ? "R6" : "R4"), "drv_high", drv_high, e_hi);
                    check("R2", "pin_oe", pin_oe, e_lo | e_hi);
                    check("R7", "overlap", drv_low & drv_high, '0);
                    check("R8", "pin readback", rdata, ~e_lo);
                end
            end
        end

        // R8: floating open-drain line pulled low outside reads 0.
        wom_hi_en = 1'b1; wom_lo_en = 1'b1;
        write_reg(1'b1, 6'h3F);
        write_reg(1'b0, 6'h3F);
        check("R5", "released upper", pin_oe, '0);
        ext_low = 6'h21;
        @(negedge clk);
        check("R8", "wired-OR low", rdata, 6'h1E);
        // R6: lower group independent of upper group enable
        ext_low = '0; wom_lo_en = 1'b0; #1;
        check("R6", "lower push-pull only", drv_high, 6'h03);
        wom_hi_en = 1'b0; wom_lo_en = 1'b1; #1;
        check("R6", "upper push-pull only", drv_high, 6'h3C);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule